// File: doc/BRIEF.md
# Periodic-Observer Correctness Counter

This block scores how often a circuit with random internal delays gives the right answer when its output is sampled once every K cycles. It has three parts. The first is a set of random bit sources that redraw only at period boundaries. The second is a reference copy of the ideal combinational function. The third is a pair of saturating counters. The circuit under test sits outside the block. It is fed from the `src_bits` port, and its result comes back on `obs_y`.

At each period boundary the block does two things. It judges the circuit's output against the ideal function of the source values that were held during the period now ending, which are the values present K cycles earlier. It also draws fresh source values for the next period. The correctness factor is read as `match_cnt / obs_cnt`.

A two-state controller handles the start of a run. `ST_PRIME` is the state after reset: the first boundary only draws the sources, because no earlier period exists yet. The transition `PRIME_TO_OBSERVE` is taken on that first boundary. `ST_OBSERVE` then holds until reset, and every later boundary is an observation instant.

Top module: `kobs_correctness_counter`

## Requirements
- R1: A period boundary occurs on every K-th rising clock edge after reset is released, where K is `cfg_period`. A value of 0 is treated as 1, so a boundary then occurs on every edge.
- R2: Each bit of `src_bits` changes only on a period-boundary edge and holds its value on every other edge.
- R3: At a boundary, each source takes a fresh 16-bit pseudo-random sample in the range 1..65535 and outputs 1 exactly when the sample is less than or equal to `cfg_thresh`. A threshold of 0 therefore always gives 0, and 0xFFFF always gives 1.
- R4: The first boundary after reset draws the sources but does not change `obs_cnt` or `match_cnt`.
- R5: Every later boundary increments `obs_cnt` by one.
- R6: `match_cnt` increments at an observation boundary exactly when `obs_y` on that edge equals the ideal function of the `src_bits` values held during the period that is ending. Otherwise it holds.
- R7: The ideal function is chosen by parameter as the AND, OR or XOR of all source bits. The default is XOR.
- R8: An external circuit whose output settles on the ideal value within K−1 cycles after the sources change is scored correct at every observation.
- R9: Both counters stop at their all-ones value. Further increments leave them unchanged.
- R10: When `sclr` is high on an edge, both counters are cleared on that edge. This takes priority over any increment, and it does not disturb the period phase or the source values.
- R11: After reset, both counters are 0 and all source bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclr | input | 1 | Synchronous clear of both counters |
| cfg_period | input | PER_W | Observation period K (0 acts as 1) |
| cfg_thresh | input | 16 | Probability threshold for drawing a 1 |
| obs_y | input | 1 | Output of the circuit under observation |
| src_bits | output | N_SRC | Current source values driving the circuit |
| match_cnt | output | CNT_W | Number of correct observations |
| obs_cnt | output | CNT_W | Number of observations made |

## Verification
The observed input is driven in four patterns:
- Exactly the ideal function of the current sources, which must score every observation as correct.
- Its inverse, which must score none.
- A free-running pseudo-random bit, whose score is checked against an independent model. This separates comparing against the ending period from comparing against the new draw.
- A delayed copy of the ideal value. This shows that settling within K−1 cycles always passes, while a longer delay is scored only as the model predicts.

Thresholds of 0, 0xFFFF and half-scale check the probability control. A zero period, a small counter width, and a clear pulse placed off the boundary cover R1, R9 and R10.

// File: rtl/kobs_pkg.sv
package kobs_pkg;

    // Ideal reference function applied to all source bits
    typedef enum logic [1:0] {
        FN_AND = 2'd0,
        FN_OR  = 2'd1,
        FN_XOR = 2'd2
    } ref_fn_e;

    // Observation controller states
    typedef enum logic {
        ST_PRIME   = 1'b0,
        ST_OBSERVE = 1'b1
    } obs_state_e;

    localparam int SAMPLE_W = 16;

endpackage

// File: rtl/kobs_src.sv
module kobs_src #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        draw,
    input  logic [15:0] thresh,
    output logic        bit_q
);

    logic [15:0] lfsr_q;
    logic [15:0] lfsr_d;

    // Galois LFSR, maximal length, never reaches zero
    always_comb begin
        lfsr_d = {1'b0, lfsr_q[15:1]};
        if (lfsr_q[0]) begin
            lfsr_d = lfsr_d ^ 16'hB400;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
            bit_q  <= 1'b0;
        end else begin
            lfsr_q <= lfsr_d;
            if (draw) begin
                bit_q <= (lfsr_q <= thresh);
            end
        end
    end

    // Source value only moves at a period boundary
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !draw |=> $stable(bit_q));

endmodule

// File: rtl/kobs_ref.sv
module kobs_ref
    import kobs_pkg::*;
#(
    parameter int      N  = 3,
    parameter ref_fn_e FN = FN_XOR
) (
    input  logic [N-1:0] v,
    output logic         y
);

    generate
        if (FN == FN_AND) begin : g_and
            assign y = &v;
        end else if (FN == FN_OR) begin : g_or
            assign y = |v;
        end else begin : g_xor
            assign y = ^v;
        end
    endgenerate

endmodule

// File: rtl/kobs_satcnt.sv
module kobs_satcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CMAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CMAX)) begin
            cnt <= cnt + W'(1);
        end
    end

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CMAX && !clr) |=> (cnt == CMAX));

endmodule

// File: rtl/kobs_correctness_counter.sv
module kobs_correctness_counter
    import kobs_pkg::*;
#(
    parameter int          N_SRC     = 3,
    parameter int          PER_W     = 16,
    parameter int          CNT_W     = 32,
    parameter ref_fn_e     FN        = FN_XOR,
    parameter logic [15:0] SEED_BASE = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclr,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [15:0]      cfg_thresh,
    input  logic             obs_y,
    output logic [N_SRC-1:0] src_bits,
    output logic [CNT_W-1:0] match_cnt,
    output logic [CNT_W-1:0] obs_cnt
);

    logic [PER_W-1:0] phase_q;
    logic [PER_W-1:0] last_phase;
    logic             tick;
    logic             ref_y;
    logic             obs_inc;
    logic             match_inc;
    obs_state_e       state_q;
    obs_state_e       state_d;

    // Period phase: a zero period behaves as one
    assign last_phase = (cfg_period == '0) ? '0 : (cfg_period - PER_W'(1));
    assign tick       = (phase_q >= last_phase);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PER_W'(1);
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: PRIME_TO_OBSERVE on the first boundary
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME:   if (tick) state_d = ST_OBSERVE;
            ST_OBSERVE: state_d = ST_OBSERVE;
            default:    state_d = ST_PRIME;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        obs_inc   = 1'b0;
        match_inc = 1'b0;
        unique case (state_q)
            ST_PRIME: begin
                obs_inc   = 1'b0;
                match_inc = 1'b0;
            end
            ST_OBSERVE: begin
                obs_inc   = tick;
                match_inc = tick && (obs_y == ref_y);
            end
            default: begin
                obs_inc   = 1'b0;
                match_inc = 1'b0;
            end
        endcase
    end

    // Random sources, one per input of the observed circuit
    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            localparam int          MIX  = (i * 15643) % 32768;
            localparam logic [15:0] SEED = {SEED_BASE[15:1] ^ 15'(MIX), 1'b1};
            kobs_src #(
                .SEED (SEED)
            ) u_src (
                .clk    (clk),
                .rst_n  (rst_n),
                .draw   (tick),
                .thresh (cfg_thresh),
                .bit_q  (src_bits[i])
            );
        end
    endgenerate

    // The sources still hold the ending period's draw at the boundary
    kobs_ref #(
        .N  (N_SRC),
        .FN (FN)
    ) u_ref (
        .v (src_bits),
        .y (ref_y)
    );

    kobs_satcnt #(
        .W (CNT_W)
    ) u_obs_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sclr),
        .inc   (obs_inc),
        .cnt   (obs_cnt)
    );

    kobs_satcnt #(
        .W (CNT_W)
    ) u_match_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sclr),
        .inc   (match_inc),
        .cnt   (match_cnt)
    );

    assert_match_le_obs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_cnt <= obs_cnt);

    assert_prime_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME && !sclr) |=> $stable(obs_cnt));

endmodule

// File: tb/kobs_correctness_counter_bench.sv
`timescale 1ns/1ps
module kobs_correctness_counter_bench;

    localparam int NS   = 3;
    localparam int PW   = 16;
    localparam int CW   = 5;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sclr;
    logic [PW-1:0] cfg_period;
    logic [15:0]   cfg_thresh;
    logic          obs_y;
    logic [NS-1:0] src_bits;
    logic [CW-1:0] match_cnt;
    logic [CW-1:0] obs_cnt;

    always #2 clk = ~clk;

    kobs_correctness_counter #(
        .N_SRC (NS),
        .PER_W (PW),
        .CNT_W (CW)
    ) u_kobs_correctness_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclr       (sclr),
        .cfg_period (cfg_period),
        .cfg_thresh (cfg_thresh),
        .obs_y      (obs_y),
        .src_bits   (src_bits),
        .match_cnt  (match_cnt),
        .obs_cnt    (obs_cnt)
    );

    int          n_run  = 0;
    int          n_fail = 0;
    int          exp_obs, exp_match;
    int          obs_err, match_err, hold_err;
    bit          seen1, seen0;
    logic [63:0] fhist;
    logic [15:0] bl;

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #600000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    task automatic do_reset(input int k, input logic [15:0] thr);
        @(negedge clk);
        rst_n      = 1'b0;
        sclr       = 1'b0;
        obs_y      = 1'b0;
        cfg_period = PW'(k);
        cfg_thresh = thr;
        fhist      = '0;
        bl         = 16'h1357;
        exp_obs    = 0;
        exp_match  = 0;
        obs_err    = 0;
        match_err  = 0;
        hold_err   = 0;
        seen1      = 1'b0;
        seen0      = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // mode 0: ideal, 1: inverted, 2: pseudo-random, 3: ideal delayed by d
    task automatic run(input int c0, input int cycles, input int k,
                       input int mode, input int d, input int sclr_at);
        int            keff;
        logic [NS-1:0] ps;
        logic          y;
        keff = (k == 0) ? 1 : k;
        for (int c = c0 + 1; c <= c0 + cycles; c++) begin
            ps    = src_bits;
            fhist = {fhist[62:0], ^src_bits};
            case (mode)
                0:       y = ^src_bits;
                1:       y = ~(^src_bits);
                2: begin
                    y  = bl[0];
                    bl = {bl[14:0], bl[15] ^ bl[13] ^ bl[12] ^ bl[10]};
                end
                default: y = fhist[d];
            endcase
            obs_y = y;
            sclr  = (c == sclr_at);
            @(posedge clk);
            @(negedge clk);
            if (c == sclr_at) begin
                exp_obs   = 0;
                exp_match = 0;
            end else if ((c % keff) == 0 && c >= 2 * keff) begin
                if (exp_obs < CMAX) exp_obs++;
                if (y == ^ps && exp_match < CMAX) exp_match++;
            end
            if (int'(obs_cnt) != exp_obs) obs_err++;
            if (int'(match_cnt) != exp_match) match_err++;
            if ((c % keff) != 0 && src_bits != ps) hold_err++;
            if (c >= keff) begin
                if (|src_bits) seen1 = 1'b1;
                if (~&src_bits) seen0 = 1'b1;
            end
        end
        sclr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(4, 16'h8000);
        check(obs_cnt == '0, "R11 obs_cnt after reset", int'(obs_cnt), 0);
        check(match_cnt == '0, "R11 match_cnt after reset", int'(match_cnt), 0);
        check(src_bits == '0, "R11 src_bits after reset", int'(src_bits), 0);
    endtask

    task automatic t_first_skip();
        do_reset(4, 16'h8000);
        run(0, 7, 4, 0, 0, -1);
        check(obs_cnt == '0, "R4 no observation on first boundary", int'(obs_cnt), 0);
        run(7, 1, 4, 0, 0, -1);
        check(obs_cnt == CW'(1), "R5 first observation at edge 2K", int'(obs_cnt), 1);
    endtask

    task automatic t_correct();
        do_reset(5, 16'h8000);
        run(0, 120, 5, 0, 0, -1);
        check(obs_err == 0, "R1 R5 observation cadence", obs_err, 0);
        check(obs_cnt == CW'(23), "R5 observation count", int'(obs_cnt), 23);
        check(match_cnt == CW'(23), "R8 ideal circuit always correct", int'(match_cnt), 23);
        check(hold_err == 0, "R2 sources hold between boundaries", hold_err, 0);
        check(seen1 && seen0, "R3 half-scale threshold draws both values", int'(seen1) + int'(seen0), 2);
    endtask

    task automatic t_wrong();
        do_reset(3, 16'h8000);
        run(0, 60, 3, 1, 0, -1);
        check(obs_cnt == CW'(19), "R5 observation count K=3", int'(obs_cnt), 19);
        check(match_cnt == '0, "R6 inverted output never matches", int'(match_cnt), 0);
    endtask

    task automatic t_random();
        do_reset(4, 16'h6000);
        run(0, 100, 4, 2, 0, -1);
        check(match_err == 0, "R6 R7 XOR reference vs random output", match_err, 0);
        check(hold_err == 0, "R2 hold under random output", hold_err, 0);
    endtask

    task automatic t_delay();
        do_reset(6, 16'h8000);
        run(0, 90, 6, 3, 5, -1);
        check(match_cnt == obs_cnt && obs_cnt == CW'(14), "R8 settle within K-1 all correct",
              int'(match_cnt), 14);
        do_reset(3, 16'h8000);
        run(0, 90, 3, 3, 5, -1);
        check(match_err == 0, "R6 late output scored against ending period", match_err, 0);
    endtask

    task automatic t_thresh();
        do_reset(2, 16'h0000);
        run(0, 40, 2, 0, 0, -1);
        check(!seen1, "R3 threshold 0 never draws 1", int'(seen1), 0);
        do_reset(2, 16'hFFFF);
        run(0, 40, 2, 0, 0, -1);
        check(!seen0, "R3 threshold 0xFFFF always draws 1", int'(seen0), 0);
    endtask

    task automatic t_k0();
        do_reset(0, 16'h8000);
        run(0, 20, 0, 0, 0, -1);
        check(obs_cnt == CW'(19), "R1 zero period acts as one", int'(obs_cnt), 19);
    endtask

    task automatic t_sat();
        do_reset(1, 16'h8000);
        run(0, 50, 1, 0, 0, -1);
        check(obs_cnt == CW'(CMAX), "R9 obs_cnt saturates", int'(obs_cnt), CMAX);
        check(match_cnt == CW'(CMAX), "R9 match_cnt saturates", int'(match_cnt), CMAX);
    endtask

    task automatic t_sclr();
        do_reset(4, 16'h8000);
        run(0, 40, 4, 0, 0, 22);
        check(obs_err == 0 && match_err == 0, "R10 clear and unchanged phase", obs_err + match_err, 0);
        check(obs_cnt == CW'(5), "R10 count restarts after clear", int'(obs_cnt), 5);
        check(hold_err == 0, "R10 R2 clear leaves sources alone", hold_err, 0);
    endtask

    initial begin
        rst_n      = 1'b0;
        sclr       = 1'b0;
        obs_y      = 1'b0;
        cfg_period = '0;
        cfg_thresh = '0;
        t_reset();
        t_first_skip();
        t_correct();
        t_wrong();
        t_random();
        t_delay();
        t_thresh();
        t_k0();
        t_sat();
        t_sclr();
        summary();
        $finish;
    end

endmodule